// File: doc/BRIEF.md
# I2C Target Front End with General-Call Handling

This block is the receive-side front end of an I2C target. A fast system clock oversamples the open-drain SDA and SCL lines through synchronizer flops and turns them into START, STOP and SCL edge events. After a START the first byte is shifted in. Its 7-bit address is compared against four separately programmed target addresses. On a match the target pulls SDA low for the acknowledge clock and then takes part in the transfer. On a mismatch it lets go of the bus until the next START or repeated START.

General-call traffic (address zero with a write direction) is accepted when enabled. The first byte after it is decoded. A reset command returns the interface to idle after its acknowledge. A reprogram command only raises a status flag. A byte equal to an alternate address marks a hardware general call. Further outputs give a stop interrupt, which fires only if an address was acknowledged earlier in the transfer, a transmit-data request right after the read/write bit of a read, and clock stretching that holds SCL low. Configuration arrives as plain input ports. The open-drain pins are modelled as drive-low enables.

Top module: `i2c_tgt_gc`

## Requirements
- R1: While `enable_i` is low the target never acknowledges, never drives SDA and never reports an address hit.
- R2: The first byte after a START carries the address in bits 7..1, sent MSB first, and the read/write flag in bit 0 (1 = read). If the address is nonzero and equals slot k (`tgt_addr_i[7k+6:7k]`), the target drives SDA low during the ninth SCL clock and sets `addr_hit_o` to 1. It sets `hit_idx_o` to the lowest matching slot and `rw_o` to the read/write flag.
- R3: On an address mismatch SDA is left released and the rest of the transfer is ignored: data bytes get no acknowledge and `rx_valid_o` does not pulse. A repeated START evaluates a new address.
- R4: While addressed for a write, every data byte is acknowledged and presented on `rx_data_o` together with a one-cycle `rx_valid_o` pulse.
- R5: With `gc_en_i` set, address byte 0x00 is acknowledged and `gc_mode_o` becomes 1. With `gc_en_i` clear it is not acknowledged.
- R6: A first general-call data byte of 0x06 is acknowledged and sets `gc_stat_o` = 1 and `gc_cmd_o` = 2'b10. At the end of its acknowledge clock the target returns to idle: `addr_hit_o` goes to 0, later bytes are not acknowledged, and the following STOP raises no stop interrupt.
- R7: A first general-call data byte of 0x04 sets `gc_stat_o` = 1 and `gc_cmd_o` = 2'b01. The target stays addressed.
- R8: With both `hwgc_en_i` and `gc_en_i` set, a first general-call data byte equal to the 8-bit `alt_addr_i` sets `hwgc_stat_o` and leaves `gc_stat_o` unchanged. With `hwgc_en_i` clear no hardware-general-call status is set.
- R9: `stop_irq_o` pulses for exactly one cycle on a STOP, and only when `stop_ie_i` is set and an address (general call included) was acknowledged since the previous STOP. A repeated START does not clear that record.
- R10: With `txreq_en_i` set, `txreq_o` pulses for one cycle after the SCL fall that ends the read/write bit of an acknowledged read address. Writes produce no pulse.
- R11: With `stretch_i` set, `scl_low_o` asserts at once if SCL is already low, or otherwise at the next SCL fall. It stays asserted until `stretch_i` clears, and is released one cycle later.
- R12: One cycle after `gc_clr_i` is sampled high, `gc_stat_o` and `hwgc_stat_o` are 0 and `gc_cmd_o` is 2'b00. A clear wins over a set in the same cycle.
- R13: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_low_o | output | 1 | Pull SCL low (stretch) |
| sda_low_o | output | 1 | Pull SDA low (acknowledge) |
| enable_i | input | 1 | Target enable |
| gc_en_i | input | 1 | Accept general call |
| hwgc_en_i | input | 1 | Compare general-call byte with alternate address |
| stop_ie_i | input | 1 | Stop interrupt enable |
| txreq_en_i | input | 1 | Transmit request enable |
| stretch_i | input | 1 | Hold SCL low |
| gc_clr_i | input | 1 | Clear general-call status |
| tgt_addr_i | input | 28 | Four 7-bit target addresses, slot k at bits 7k+6..7k |
| alt_addr_i | input | 8 | Alternate address byte for hardware general call |
| addr_hit_o | output | 1 | Currently addressed |
| hit_idx_o | output | 2 | Matching slot index |
| rw_o | output | 1 | Read/write flag of the accepted address |
| gc_mode_o | output | 1 | Addressed by general call |
| gc_stat_o | output | 1 | General-call command status |
| hwgc_stat_o | output | 1 | Hardware general call status |
| gc_cmd_o | output | 2 | Last command: 01 reprogram, 10 reset |
| stop_irq_o | output | 1 | Stop interrupt pulse |
| txreq_o | output | 1 | Transmit data request pulse |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | Data byte strobe |

## Verification
Every result that depends on the bus shows up three system cycles after the SDA or SCL change that causes it: two synchronizer flops plus the state register. The bench moves the lines only every eight cycles and samples the bus and the status ports a full quarter-bit after each edge, so every result has already settled. A change on `stretch_i` or `gc_clr_i` takes effect one cycle later, and those checks sample one falling clock edge after the input is driven. The one-cycle pulses are counted on every clock edge and compared as counts after each byte or STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ADDR  = 3'd1,
        ST_ACK   = 3'd2,
        ST_WDATA = 3'd3,
        ST_READ  = 3'd4,
        ST_SKIP  = 3'd5
    } tgt_state_e;

    typedef enum logic [1:0] {
        GCC_NONE   = 2'b00,
        GCC_REPROG = 2'b01,
        GCC_RESET  = 2'b10
    } gc_cmd_e;

    localparam logic [7:0] GC_BYTE_RESET  = 8'h06;
    localparam logic [7:0] GC_BYTE_REPROG = 8'h04;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl_lvl;
        logic sda_lvl;
    } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } sync_t;

    sync_t s_d, s_q;
    logic  scl_now, scl_prev, sda_now, sda_prev;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[STAGES-1:0], scl_i};
        s_d.sda = {s_q.sda[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    assign scl_now  = s_q.scl[STAGES-1];
    assign scl_prev = s_q.scl[STAGES];
    assign sda_now  = s_q.sda[STAGES-1];
    assign sda_prev = s_q.sda[STAGES];

    always_comb begin
        ev_o.scl_lvl  = scl_now;
        ev_o.sda_lvl  = sda_now;
        ev_o.scl_rise = scl_now & ~scl_prev;
        ev_o.scl_fall = ~scl_now & scl_prev;
        ev_o.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev_o.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch (
    input  logic clk,
    input  logic rst_n,
    input  logic stretch_en,
    input  logic scl_lvl,
    output logic scl_low_o
);

    typedef struct packed {
        logic hold;
    } str_t;

    str_t h_d, h_q;

    // A low line covers both cases: already low, or just fallen.
    always_comb begin
        h_d      = h_q;
        h_d.hold = stretch_en & (h_q.hold | ~scl_lvl);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign scl_low_o = h_q.hold;

    AST_STRETCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !stretch_en |=> !h_q.hold); // R11
    AST_STRETCH_GRAB: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_en && !scl_lvl |=> h_q.hold); // R11
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        h_q.hold && stretch_en |=> h_q.hold); // R11

endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_ADDR = 4,
    parameter int ADDR_W   = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  bus_ev_t                      ev,
    input  logic                         enable_i,
    input  logic                         gc_en_i,
    input  logic                         hwgc_en_i,
    input  logic                         stop_ie_i,
    input  logic                         txreq_en_i,
    input  logic                         gc_clr_i,
    input  logic [NUM_ADDR*ADDR_W-1:0]   tgt_addr_i,
    input  logic [ADDR_W:0]              alt_addr_i,
    output logic                         sda_low_o,
    output logic                         addr_hit_o,
    output logic [$clog2(NUM_ADDR)-1:0]  hit_idx_o,
    output logic                         rw_o,
    output logic                         gc_mode_o,
    output logic                         gc_stat_o,
    output logic                         hwgc_stat_o,
    output logic [1:0]                   gc_cmd_o,
    output logic                         stop_irq_o,
    output logic                         txreq_o,
    output logic [ADDR_W:0]              rx_data_o,
    output logic                         rx_valid_o
);

    localparam int BYTE_W = ADDR_W + 1;
    localparam int IDX_W  = $clog2(NUM_ADDR);
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef struct packed {
        tgt_state_e        state;
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  bitcnt;
        logic              rw;
        logic              sda_low;
        logic              addr_hit;
        logic              matched;
        logic              gc_mode;
        logic              gc_first;
        logic              gc_rst_pend;
        logic              gc_stat;
        logic              hwgc_stat;
        gc_cmd_e           gc_cmd;
        logic [IDX_W-1:0]  hit_idx;
        logic              stop_irq;
        logic              txreq;
        logic              rx_valid;
        logic [BYTE_W-1:0] rx_data;
    } core_t;

    core_t r_d, r_q;

    logic [NUM_ADDR-1:0] hit_vec;
    logic                any_hit;
    logic [IDX_W-1:0]    hit_sel;
    logic                byte_done;
    logic                addr_zero;

    // One comparator per address slot.
    for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
        assign hit_vec[g] = (r_q.shreg[BYTE_W-1:1] == tgt_addr_i[g*ADDR_W +: ADDR_W]);
    end

    // Lowest slot wins when several hold the same address.
    always_comb begin
        any_hit = 1'b0;
        hit_sel = '0;
        for (int i = NUM_ADDR - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                hit_sel = IDX_W'(i);
            end
        end
    end

    assign byte_done = (r_q.bitcnt == CNT_W'(BYTE_W));
    assign addr_zero = (r_q.shreg[BYTE_W-1:1] == '0);

    always_comb begin
        r_d          = r_q;
        r_d.stop_irq = 1'b0;
        r_d.txreq    = 1'b0;
        r_d.rx_valid = 1'b0;

        if (!enable_i) begin
            r_d.state    = ST_IDLE;
            r_d.sda_low  = 1'b0;
            r_d.addr_hit = 1'b0;
            r_d.matched  = 1'b0;
            r_d.gc_mode  = 1'b0;
        end else if (ev.stop) begin
            r_d.stop_irq    = stop_ie_i & r_q.matched;
            r_d.state       = ST_IDLE;
            r_d.sda_low     = 1'b0;
            r_d.addr_hit    = 1'b0;
            r_d.matched     = 1'b0;
            r_d.gc_mode     = 1'b0;
            r_d.gc_rst_pend = 1'b0;
        end else if (ev.start) begin
            r_d.state       = ST_ADDR;
            r_d.bitcnt      = '0;
            r_d.sda_low     = 1'b0;
            r_d.addr_hit    = 1'b0;
            r_d.gc_mode     = 1'b0;
            r_d.gc_rst_pend = 1'b0;
        end else if (ev.scl_rise) begin
            if (r_q.state == ST_ADDR || r_q.state == ST_WDATA) begin
                r_d.shreg  = {r_q.shreg[BYTE_W-2:0], ev.sda_lvl};
                r_d.bitcnt = r_q.bitcnt + CNT_W'(1);
            end
        end else if (ev.scl_fall) begin
            case (r_q.state)
                ST_ADDR: begin
                    if (byte_done) begin
                        if (addr_zero) begin
                            if (!r_q.shreg[0] && gc_en_i) begin
                                r_d.state    = ST_ACK;
                                r_d.sda_low  = 1'b1;
                                r_d.addr_hit = 1'b1;
                                r_d.matched  = 1'b1;
                                r_d.gc_mode  = 1'b1;
                                r_d.gc_first = 1'b1;
                                r_d.rw       = 1'b0;
                            end else begin
                                r_d.state = ST_SKIP;
                            end
                        end else if (any_hit) begin
                            r_d.state    = ST_ACK;
                            r_d.sda_low  = 1'b1;
                            r_d.addr_hit = 1'b1;
                            r_d.matched  = 1'b1;
                            r_d.hit_idx  = hit_sel;
                            r_d.rw       = r_q.shreg[0];
                            r_d.txreq    = r_q.shreg[0] & txreq_en_i;
                        end else begin
                            r_d.state = ST_SKIP;
                        end
                    end
                end
                ST_ACK: begin
                    r_d.sda_low = 1'b0;
                    r_d.bitcnt  = '0;
                    if (r_q.gc_rst_pend) begin
                        r_d.state       = ST_IDLE;
                        r_d.addr_hit    = 1'b0;
                        r_d.matched     = 1'b0;
                        r_d.gc_mode     = 1'b0;
                        r_d.gc_rst_pend = 1'b0;
                    end else begin
                        r_d.state = r_q.rw ? ST_READ : ST_WDATA;
                    end
                end
                ST_WDATA: begin
                    if (byte_done) begin
                        r_d.state    = ST_ACK;
                        r_d.sda_low  = 1'b1;
                        r_d.rx_data  = r_q.shreg;
                        r_d.rx_valid = 1'b1;
                        if (r_q.gc_mode && r_q.gc_first) begin
                            r_d.gc_first = 1'b0;
                            if (hwgc_en_i && gc_en_i && r_q.shreg == alt_addr_i) begin
                                r_d.hwgc_stat = 1'b1;
                            end else if (r_q.shreg == BYTE_W'(GC_BYTE_RESET)) begin
                                r_d.gc_stat     = 1'b1;
                                r_d.gc_cmd      = GCC_RESET;
                                r_d.gc_rst_pend = 1'b1;
                            end else if (r_q.shreg == BYTE_W'(GC_BYTE_REPROG)) begin
                                r_d.gc_stat = 1'b1;
                                r_d.gc_cmd  = GCC_REPROG;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end

        if (gc_clr_i) begin
            r_d.gc_stat   = 1'b0;
            r_d.hwgc_stat = 1'b0;
            r_d.gc_cmd    = GCC_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sda_low_o   = r_q.sda_low;
    assign addr_hit_o  = r_q.addr_hit;
    assign hit_idx_o   = r_q.hit_idx;
    assign rw_o        = r_q.rw;
    assign gc_mode_o   = r_q.gc_mode;
    assign gc_stat_o   = r_q.gc_stat;
    assign hwgc_stat_o = r_q.hwgc_stat;
    assign gc_cmd_o    = r_q.gc_cmd;
    assign stop_irq_o  = r_q.stop_irq;
    assign txreq_o     = r_q.txreq;
    assign rx_data_o   = r_q.rx_data;
    assign rx_valid_o  = r_q.rx_valid;

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !r_q.sda_low && !r_q.addr_hit); // R1
    AST_SDA_ON_LOW_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(r_q.sda_low) && $past(enable_i) |-> !$past(ev.scl_lvl)); // R2
    AST_STOP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stop_irq |-> $past(r_q.matched) && $past(stop_ie_i)); // R9
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.stop_irq |=> !r_q.stop_irq); // R9
    AST_TXREQ_READ: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.txreq |-> r_q.rw && r_q.addr_hit && $past(txreq_en_i)); // R10
    AST_TXREQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.txreq |=> !r_q.txreq); // R10
    AST_GC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        gc_clr_i |=> !r_q.gc_stat && !r_q.hwgc_stat && r_q.gc_cmd == GCC_NONE); // R12
    AST_GC_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.gc_rst_pend) && enable_i && !$past(ev.stop) && !$past(ev.start)
        |-> !r_q.addr_hit); // R6

endmodule

// File: rtl/i2c_tgt_gc.sv
module i2c_tgt_gc
    import i2c_tgt_pkg::*;
#(
    parameter int NUM_ADDR    = 4,
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         scl_i,
    input  logic                         sda_i,
    output logic                         scl_low_o,
    output logic                         sda_low_o,
    input  logic                         enable_i,
    input  logic                         gc_en_i,
    input  logic                         hwgc_en_i,
    input  logic                         stop_ie_i,
    input  logic                         txreq_en_i,
    input  logic                         stretch_i,
    input  logic                         gc_clr_i,
    input  logic [NUM_ADDR*ADDR_W-1:0]   tgt_addr_i,
    input  logic [ADDR_W:0]              alt_addr_i,
    output logic                         addr_hit_o,
    output logic [$clog2(NUM_ADDR)-1:0]  hit_idx_o,
    output logic                         rw_o,
    output logic                         gc_mode_o,
    output logic                         gc_stat_o,
    output logic                         hwgc_stat_o,
    output logic [1:0]                   gc_cmd_o,
    output logic                         stop_irq_o,
    output logic                         txreq_o,
    output logic [ADDR_W:0]              rx_data_o,
    output logic                         rx_valid_o
);

    bus_ev_t ev;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    i2c_tgt_stretch u_stretch (
        .clk        (clk),
        .rst_n      (rst_n),
        .stretch_en (stretch_i),
        .scl_lvl    (ev.scl_lvl),
        .scl_low_o  (scl_low_o)
    );

    i2c_tgt_core #(.NUM_ADDR(NUM_ADDR), .ADDR_W(ADDR_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .ev          (ev),
        .enable_i    (enable_i),
        .gc_en_i     (gc_en_i),
        .hwgc_en_i   (hwgc_en_i),
        .stop_ie_i   (stop_ie_i),
        .txreq_en_i  (txreq_en_i),
        .gc_clr_i    (gc_clr_i),
        .tgt_addr_i  (tgt_addr_i),
        .alt_addr_i  (alt_addr_i),
        .sda_low_o   (sda_low_o),
        .addr_hit_o  (addr_hit_o),
        .hit_idx_o   (hit_idx_o),
        .rw_o        (rw_o),
        .gc_mode_o   (gc_mode_o),
        .gc_stat_o   (gc_stat_o),
        .hwgc_stat_o (hwgc_stat_o),
        .gc_cmd_o    (gc_cmd_o),
        .stop_irq_o  (stop_irq_o),
        .txreq_o     (txreq_o),
        .rx_data_o   (rx_data_o),
        .rx_valid_o  (rx_valid_o)
    );

    AST_ACK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        sda_low_o |-> addr_hit_o); // R2
    AST_STOP_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_irq_o) |-> !addr_hit_o); // R9

endmodule

// File: tb/tb_i2c_tgt_gc.sv
`timescale 1ns/1ps
module tb_i2c_tgt_gc;

    localparam int Q = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic enable = 1'b0, gc_en = 1'b0, hwgc_en = 1'b0, stop_ie = 1'b0;
    logic txreq_en = 1'b0, stretch = 1'b0, gc_clr = 1'b0;
    logic [27:0] tgt_addr;
    logic [7:0]  alt_addr = 8'h00;
    logic scl_low_o, sda_low_o, addr_hit_o, rw_o, gc_mode_o, gc_stat_o, hwgc_stat_o;
    logic stop_irq_o, txreq_o, rx_valid_o;
    logic [1:0] hit_idx_o, gc_cmd_o;
    logic [7:0] rx_data_o;
    logic scl_bus, sda_bus;

    assign scl_bus = scl_m & ~scl_low_o;
    assign sda_bus = sda_m & ~sda_low_o;

    i2c_tgt_gc dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o),
        .enable_i(enable), .gc_en_i(gc_en), .hwgc_en_i(hwgc_en), .stop_ie_i(stop_ie),
        .txreq_en_i(txreq_en), .stretch_i(stretch), .gc_clr_i(gc_clr),
        .tgt_addr_i(tgt_addr), .alt_addr_i(alt_addr),
        .addr_hit_o(addr_hit_o), .hit_idx_o(hit_idx_o), .rw_o(rw_o), .gc_mode_o(gc_mode_o),
        .gc_stat_o(gc_stat_o), .hwgc_stat_o(hwgc_stat_o), .gc_cmd_o(gc_cmd_o),
        .stop_irq_o(stop_irq_o), .txreq_o(txreq_o), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o)
    );

    int n_cmp = 0, n_bad = 0;
    int stop_cnt = 0, txq_cnt = 0, rx_cnt = 0;
    logic [7:0] last_rx = 8'h00;
    bit done = 1'b0;
    int slots [4] = '{7'h12, 7'h3A, 7'h55, 7'h6C};

    always @(posedge clk) begin
        if (stop_irq_o) stop_cnt <= stop_cnt + 1;
        if (txreq_o)    txq_cnt  <= txq_cnt + 1;
        if (rx_valid_o) begin
            rx_cnt  <= rx_cnt + 1;
            last_rx <= rx_data_o;
        end
    end

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic load_slots();
        for (int i = 0; i < 4; i++) tgt_addr[i*7 +: 7] = 7'(slots[i]);
    endtask

    function automatic int exp_slot(input int a);
        for (int i = 0; i < 4; i++) if (a != 0 && a == slots[i]) return i;
        return -1;
    endfunction

    task automatic m_start();
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
    endtask

    task automatic m_bit(input logic b);
        sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    endtask

    task automatic m_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) m_bit(b[i]);
        sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
    endtask

    logic ack;
    int s0, t0, r0, a, rw, nb, e;
    logic [7:0] d;

    initial begin
        void'($urandom(32'd9127));
        load_slots();
        wq(4);
        rst_n = 1'b1;
        wq(2);
        // R13 reset state
        chk("R13", "sda_low", sda_low_o, 0);
        chk("R13", "scl_low", scl_low_o, 0);
        chk("R13", "addr_hit", addr_hit_o, 0);
        chk("R13", "gc_stat", gc_stat_o, 0);
        chk("R13", "stop_irq", stop_irq_o, 0);

        // R1 disabled target stays silent
        stop_ie = 1'b1;
        s0 = stop_cnt;
        m_start(); m_byte({7'h12, 1'b0}, ack);
        chk("R1", "ack while disabled", ack, 0);
        chk("R1", "addr_hit while disabled", addr_hit_o, 0);
        m_stop();
        chk("R1", "stop irq while disabled", stop_cnt - s0, 0);
        enable = 1'b1;

        // R3 mismatch ignored, repeated start re-evaluates; R9 sticky record
        s0 = stop_cnt; r0 = rx_cnt;
        m_start(); m_byte({7'h7F, 1'b0}, ack);
        chk("R3", "ack on mismatch", ack, 0);
        m_byte(8'hAA, ack);
        chk("R3", "ack data after mismatch", ack, 0);
        chk("R3", "rx strobes after mismatch", rx_cnt - r0, 0);
        m_start(); m_byte({7'h3A, 1'b0}, ack);
        chk("R3", "ack after repeated start", ack, 1);
        chk("R2", "hit_idx slot1", hit_idx_o, 1);
        m_start(); m_byte({7'h01, 1'b0}, ack);
        chk("R3", "ack second mismatch", ack, 0);
        m_stop();
        chk("R9", "stop irq after earlier match", stop_cnt - s0, 1);

        // R9 stop_ie clear
        stop_ie = 1'b0; s0 = stop_cnt;
        m_start(); m_byte({7'h55, 1'b0}, ack); m_stop();
        chk("R9", "stop irq with enable clear", stop_cnt - s0, 0);
        stop_ie = 1'b1;

        // R10 transmit request
        txreq_en = 1'b1; t0 = txq_cnt;
        m_start(); m_byte({7'h55, 1'b1}, ack);
        chk("R10", "read ack", ack, 1);
        chk("R10", "rw_o read", rw_o, 1);
        chk("R10", "txreq on read", txq_cnt - t0, 1);
        m_stop();
        t0 = txq_cnt;
        m_start(); m_byte({7'h55, 1'b0}, ack); m_stop();
        chk("R10", "txreq on write", txq_cnt - t0, 0);
        txreq_en = 1'b0; t0 = txq_cnt;
        m_start(); m_byte({7'h55, 1'b1}, ack); m_stop();
        chk("R10", "txreq disabled", txq_cnt - t0, 0);

        // R4 write data
        r0 = rx_cnt;
        m_start(); m_byte({7'h6C, 1'b0}, ack);
        chk("R2", "hit_idx slot3", hit_idx_o, 3);
        m_byte(8'hA5, ack);
        chk("R4", "data ack 1", ack, 1);
        m_byte(8'h3C, ack);
        chk("R4", "data ack 2", ack, 1);
        chk("R4", "last rx", last_rx, 8'h3C);
        chk("R4", "rx strobes", rx_cnt - r0, 2);
        m_stop();

        // R2 duplicate slot, lowest index wins
        slots[3] = 7'h12; load_slots();
        m_start(); m_byte({7'h12, 1'b0}, ack);
        chk("R2", "dup ack", ack, 1);
        chk("R2", "dup lowest idx", hit_idx_o, 0);
        m_stop();
        slots[3] = 7'h6C; load_slots();

        // R5 general call disabled / enabled
        m_start(); m_byte(8'h00, ack);
        chk("R5", "gc ack while disabled", ack, 0);
        m_stop();
        gc_en = 1'b1; s0 = stop_cnt;
        m_start(); m_byte(8'h00, ack);
        chk("R5", "gc ack", ack, 1);
        chk("R5", "gc_mode", gc_mode_o, 1);
        m_byte(8'h04, ack);
        chk("R7", "reprogram ack", ack, 1);
        chk("R7", "gc_stat", gc_stat_o, 1);
        chk("R7", "gc_cmd", gc_cmd_o, 1);
        chk("R7", "still addressed", addr_hit_o, 1);
        m_stop();
        chk("R9", "stop irq after gc", stop_cnt - s0, 1);

        // R12 clear
        gc_clr = 1'b1; wq(1); gc_clr = 1'b0;
        chk("R12", "gc_stat cleared", gc_stat_o, 0);
        chk("R12", "gc_cmd cleared", gc_cmd_o, 0);

        // R6 reset command
        s0 = stop_cnt;
        m_start(); m_byte(8'h00, ack); m_byte(8'h06, ack);
        chk("R6", "reset ack", ack, 1);
        chk("R6", "gc_stat", gc_stat_o, 1);
        chk("R6", "gc_cmd", gc_cmd_o, 2);
        chk("R6", "idle after reset", addr_hit_o, 0);
        m_byte(8'h33, ack);
        chk("R6", "byte after reset", ack, 0);
        m_stop();
        chk("R6", "no stop irq after reset", stop_cnt - s0, 0);
        gc_clr = 1'b1; wq(1); gc_clr = 1'b0;

        // R8 hardware general call
        hwgc_en = 1'b1; alt_addr = 8'hB7;
        m_start(); m_byte(8'h00, ack); m_byte(8'hB7, ack);
        chk("R8", "hwgc ack", ack, 1);
        chk("R8", "hwgc_stat", hwgc_stat_o, 1);
        chk("R8", "gc_stat untouched", gc_stat_o, 0);
        m_stop();
        gc_clr = 1'b1; wq(1); gc_clr = 1'b0;
        chk("R12", "hwgc cleared", hwgc_stat_o, 0);
        hwgc_en = 1'b0;
        m_start(); m_byte(8'h00, ack); m_byte(8'hB7, ack); m_stop();
        chk("R8", "hwgc disabled", hwgc_stat_o, 0);
        gc_en = 1'b0;

        // R11 stretching
        stretch = 1'b1; wq(6);
        chk("R11", "no hold while SCL high", scl_low_o, 0);
        scl_m = 1'b0; wq(6);
        chk("R11", "hold after fall", scl_low_o, 1);
        scl_m = 1'b1; wq(6);
        chk("R11", "bus held low", scl_bus, 0);
        stretch = 1'b0; wq(1);
        chk("R11", "release", scl_low_o, 0);
        wq(6);
        scl_m = 1'b0; wq(6);
        stretch = 1'b1; wq(1);
        chk("R11", "immediate hold", scl_low_o, 1);
        stretch = 1'b0; scl_m = 1'b1; wq(6);
        chk("R11", "released bus", scl_bus, 1);

        // Random transfers (R2, R3, R4, R9, R10)
        for (int it = 0; it < 30; it++) begin
            a  = ($urandom % 2) ? slots[$urandom % 4] : int'($urandom % 128);
            rw = int'($urandom % 2);
            stop_ie  = 1'($urandom % 2);
            txreq_en = 1'($urandom % 2);
            e  = exp_slot(a);
            s0 = stop_cnt; t0 = txq_cnt; r0 = rx_cnt;
            m_start(); m_byte({7'(a), 1'(rw)}, ack);
            chk("R2", "random addr ack", ack, (e >= 0) ? 1 : 0);
            if (e >= 0) chk("R2", "random idx", hit_idx_o, e);
            chk("R10", "random txreq", txq_cnt - t0, (e >= 0 && rw == 1 && txreq_en) ? 1 : 0);
            if (rw == 0) begin
                nb = int'($urandom % 3);
                for (int k = 0; k < nb; k++) begin
                    d = 8'($urandom);
                    m_byte(d, ack);
                    chk("R4", "random data ack", ack, (e >= 0) ? 1 : 0);
                    if (e >= 0) chk("R4", "random rx data", last_rx, d);
                end
                chk("R3", "random rx count", rx_cnt - r0, (e >= 0) ? nb : 0);
            end
            m_stop();
            chk("R9", "random stop irq", stop_cnt - s0, (e >= 0 && stop_ie) ? 1 : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule